// File: doc/BRIEF.md
# Prioritized Level Interrupt Resolver

This block gathers interrupt requests from a set of internal lines into a latched request register. Each line is either level-sensitive, so its latched bit follows the line, or edge-sensitive, so its latched bit holds until software clears it. Requests arrive one event per cycle: an event names a line directly, or names an external interrupt number that a parameter table translates to an internal line. Unknown lines and unknown external numbers are dropped. A separate enable register masks the latched requests.

The lines are grouped into priority levels by one parameter mask per level. Combinational logic finds the highest level above the processor's current level that has at least one enabled, latched line. That level is driven out as the pending level together with an interrupt request flag. Software writes the enable register through a full-word write port. It clears edge-sensitive requests through a write-one-to-clear port.

Top module: `irq_level_resolver`

## Requirements
- R1: A valid event with `evt_active`=1 for line n sets request bit n. The effect shows at the outputs after the next rising clock edge.
- R2: A valid event with `evt_active`=0 clears request bit n when line n is level-sensitive (`EDGE_MASK` bit n = 0). An edge-sensitive bit (default: odd lines) stays set.
- R3: A direct event (`evt_is_ext`=0) whose `evt_num` is at or above `NUM_LINES` changes no request bit.
- R4: An external event (`evt_is_ext`=1) with `evt_num` below `EXT_COUNT` acts on the line held in table entry `evt_num`. The entry sits at bits [k*5 +: 5] of `EXT_MAP`; the default maps 0..7 to lines 1,3,6,11,16,21,26,31. An external number at or above `EXT_COUNT` is dropped.
- R5: The effective pending set is the request register ANDed with the enable register. `en_we`=1 loads `en_wdata` into the enable register at the clock edge.
- R6: `pend_level` is the highest level L with `cur_level` < L <= `NUM_LEVELS` whose mask overlaps the effective pending set, and `irq_req` is then 1. The default masks are: level 1 = lines 0-7, and level L (2..7) = lines 4L to 4L+3.
- R7: When no level qualifies, `pend_level` is 0 and `irq_req` is 0. A `cur_level` at or above the top level blocks every request.
- R8: `clr_we`=1 clears the request bits that `clr_mask` selects, but only on edge-sensitive lines; level-sensitive bits are untouched. An event that sets a bit in the same cycle wins over the clear.
- R9: Reset (`rst_n`=0) clears the request and enable registers, so `pend_level`=0 and `irq_req`=0.
- R10: `cur_level` acts on the outputs with no clock delay. Request and enable changes show one edge after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_is_ext | input | 1 | 1: `evt_num` is an external number, 0: an internal line |
| evt_num | input | 6 | Line index or external interrupt number |
| evt_active | input | 1 | 1: line asserted, 0: line deasserted |
| clr_we | input | 1 | Write-one-to-clear strobe for edge-sensitive bits |
| clr_mask | input | 32 | Bits to clear |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 32 | New enable register value |
| cur_level | input | 3 | Current processor interrupt level |
| pend_level | output | 3 | Highest qualifying level, 0 if none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The scan is exercised with one line alone at different levels. It is then run with three lines on levels 1, 4 and 7 while `cur_level` sweeps across and above them; this shows whether the scan runs from the top and whether the above-current test is strict. Enable patterns that leave a single line, or none, separate masking from latching. Deassertion and clear-port patterns on odd and even lines separate level-sensitive from edge-sensitive latching. Out-of-range direct and external numbers, and a set and clear on the same bit in one cycle, cover the corner cases.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  localparam int IDX_BITS = 8;
  localparam int MAX_LEVELS = 15;

  typedef struct packed {
    logic                valid;
    logic                active;
    logic [IDX_BITS-1:0] idx;
  } line_upd_t;

  // Index of the highest set bit, 0 when none is set.
  function automatic logic [3:0] top_index(input logic [MAX_LEVELS:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i <= MAX_LEVELS; i++) begin
      if (v[i]) r = 4'(i);
    end
    return r;
  endfunction

  // Next request register from current state, clear request and event.
  function automatic logic [255:0] next_requests(
    input logic [255:0] cur,
    input logic [255:0] edge_bits,
    input logic         clr_en,
    input logic [255:0] clr_bits,
    input line_upd_t    upd
  );
    logic [255:0] n;
    n = cur;
    if (clr_en) n = n & ~(clr_bits & edge_bits);
    if (upd.valid) begin
      if (upd.active) n[upd.idx] = 1'b1;
      else if (!edge_bits[upd.idx]) n[upd.idx] = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/irq_evt_decode.sv
module irq_evt_decode
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int EVT_W     = 6,
  parameter int EXT_COUNT = 8,
  parameter int LINE_W    = 5,
  parameter logic [EXT_COUNT*LINE_W-1:0] EXT_MAP = '0
) (
  input  logic             evt_valid,
  input  logic             evt_is_ext,
  input  logic [EVT_W-1:0] evt_num,
  input  logic             evt_active,
  output line_upd_t        upd,
  output logic             evt_drop
);

  logic [LINE_W-1:0] ext_line;
  logic              ext_known;
  logic              line_ok;
  logic [LINE_W-1:0] chosen;

  always_comb begin
    ext_line  = '0;
    ext_known = 1'b0;
    for (int k = 0; k < EXT_COUNT; k++) begin
      if (int'(evt_num) == k) begin
        ext_line  = EXT_MAP[k*LINE_W +: LINE_W];
        ext_known = 1'b1;
      end
    end
  end

  always_comb begin
    if (evt_is_ext) begin
      chosen  = ext_line;
      line_ok = ext_known && (int'(ext_line) < NUM_LINES);
    end else begin
      chosen  = evt_num[LINE_W-1:0];
      line_ok = int'(evt_num) < NUM_LINES;
    end
    upd.valid  = evt_valid && line_ok;
    upd.active = evt_active;
    upd.idx    = IDX_BITS'(chosen);
    evt_drop   = evt_valid && !line_ok;
  end

endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 5,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  line_upd_t            upd,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_mask,
  input  logic                 en_we,
  input  logic [NUM_LINES-1:0] en_wdata,
  output logic [NUM_LINES-1:0] set_q,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] eff_pend
);

  logic [255:0]         nxt_wide;
  logic [NUM_LINES-1:0] set_d;
  logic [LINE_W-1:0]    upd_line;
  logic                 edge_release;
  logic                 held_bit;

  assign upd_line = upd.idx[LINE_W-1:0];

  always_comb begin
    nxt_wide = next_requests(256'(set_q), 256'(EDGE_MASK), clr_we,
                             256'(clr_mask), upd);
    set_d    = nxt_wide[NUM_LINES-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q <= '0;
      en_q  <= '0;
    end else begin
      set_q <= set_d;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign eff_pend = set_q & en_q;

  // Named events for the checks below.
  assign edge_release = upd.valid && !upd.active && EDGE_MASK[upd_line]
                        && !(clr_we && clr_mask[upd_line]);
  assign held_bit     = set_q[upd_line];

  p_set_on_assert_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd.valid && upd.active) |=> set_q[$past(upd_line)])
    else $error("R1: asserted line not latched");

  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_release |=> (set_q[$past(upd_line)] == $past(held_bit)))
    else $error("R2: edge-sensitive bit changed on release");

  p_level_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd.valid && !upd.active && !EDGE_MASK[upd_line]) |=> !set_q[$past(upd_line)])
    else $error("R2: level-sensitive bit not cleared");

  p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(en_wdata)))
    else $error("R5: enable write lost");

  p_clear_level_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !upd.valid) |=> ((set_q & ~EDGE_MASK) == $past(set_q & ~EDGE_MASK)))
    else $error("R8: clear port touched a level-sensitive bit");

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int NUM_LEVELS = 7,
  parameter int LVL_W      = 3,
  parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASKS = '0
) (
  input  logic [NUM_LINES-1:0] eff_pend,
  input  logic [LVL_W-1:0]     cur_level,
  output logic [NUM_LEVELS:0]  level_hit,
  output logic [NUM_LEVELS:0]  level_qual,
  output logic [LVL_W-1:0]     pend_level,
  output logic                 irq_req
);

  assign level_hit[0]  = 1'b0;
  assign level_qual[0] = 1'b0;

  for (genvar L = 1; L <= NUM_LEVELS; L++) begin : g_level
    localparam logic [NUM_LINES-1:0] MASK_L = LEVEL_MASKS[(L-1)*NUM_LINES +: NUM_LINES];
    assign level_hit[L]  = |(MASK_L & eff_pend);
    assign level_qual[L] = level_hit[L] && (int'(cur_level) < L);
  end

  logic [3:0] top_lvl;

  always_comb begin
    top_lvl    = top_index((MAX_LEVELS+1)'(level_qual));
    pend_level = LVL_W'(top_lvl);
    irq_req    = |level_qual;
  end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int NUM_LEVELS = 7,
  parameter int EVT_W      = 6,
  parameter int EXT_COUNT  = 8,
  parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASKS = {
    32'hF000_0000, 32'h0F00_0000, 32'h00F0_0000, 32'h000F_0000,
    32'h0000_F000, 32'h0000_0F00, 32'h0000_00FF},
  parameter logic [NUM_LINES-1:0] EDGE_MASK = 32'hAAAA_AAAA,
  parameter logic [EXT_COUNT*5-1:0] EXT_MAP = {
    5'd31, 5'd26, 5'd21, 5'd16, 5'd11, 5'd6, 5'd3, 5'd1},
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int LVL_W  = $clog2(NUM_LEVELS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic                 evt_is_ext,
  input  logic [EVT_W-1:0]     evt_num,
  input  logic                 evt_active,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_mask,
  input  logic                 en_we,
  input  logic [NUM_LINES-1:0] en_wdata,
  input  logic [LVL_W-1:0]     cur_level,
  output logic [LVL_W-1:0]     pend_level,
  output logic                 irq_req
);

  line_upd_t            upd;
  logic                 evt_drop;
  logic [NUM_LINES-1:0] set_q;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] eff_pend;
  logic [NUM_LEVELS:0]  level_hit;
  logic [NUM_LEVELS:0]  level_qual;

  irq_evt_decode #(
    .NUM_LINES (NUM_LINES),
    .EVT_W     (EVT_W),
    .EXT_COUNT (EXT_COUNT),
    .LINE_W    (LINE_W),
    .EXT_MAP   (EXT_MAP[EXT_COUNT*LINE_W-1:0])
  ) u_decode (
    .evt_valid  (evt_valid),
    .evt_is_ext (evt_is_ext),
    .evt_num    (evt_num),
    .evt_active (evt_active),
    .upd        (upd),
    .evt_drop   (evt_drop)
  );

  irq_pend_regs #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W),
    .EDGE_MASK (EDGE_MASK)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .set_q    (set_q),
    .en_q     (en_q),
    .eff_pend (eff_pend)
  );

  irq_level_scan #(
    .NUM_LINES   (NUM_LINES),
    .NUM_LEVELS  (NUM_LEVELS),
    .LVL_W       (LVL_W),
    .LEVEL_MASKS (LEVEL_MASKS)
  ) u_scan (
    .eff_pend   (eff_pend),
    .cur_level  (cur_level),
    .level_hit  (level_hit),
    .level_qual (level_qual),
    .pend_level (pend_level),
    .irq_req    (irq_req)
  );

  p_drop_no_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_drop && !clr_we) |=> $stable(set_q))
    else $error("R3: dropped event changed the request register");

  p_above_current_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_level > cur_level))
    else $error("R6: pending level not above current level");

  p_pending_has_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> level_hit[pend_level])
    else $error("R6: pending level has no enabled line");

  p_idle_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_pend == '0) |-> (!irq_req && pend_level == '0))
    else $error("R7: request without pending lines");

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (set_q == '0 && en_q == '0))
    else $error("R9: reset left state behind");

endmodule

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_is_ext = 1'b0;
  logic [5:0]  evt_num = '0;
  logic        evt_active = 1'b0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_mask = '0;
  logic        en_we = 1'b0;
  logic [31:0] en_wdata = '0;
  logic [2:0]  cur_level = '0;
  logic [2:0]  pend_level;
  logic        irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_resolver u_irq_level_resolver (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_is_ext(evt_is_ext),
    .evt_num(evt_num), .evt_active(evt_active), .clr_we(clr_we),
    .clr_mask(clr_mask), .en_we(en_we), .en_wdata(en_wdata),
    .cur_level(cur_level), .pend_level(pend_level), .irq_req(irq_req)
  );

  // Reference model -------------------------------------------------------
  bit m_set [32];
  bit m_en  [32];

  function automatic int level_of(int line);
    return (line < 8) ? 1 : line / 4;
  endfunction

  function automatic bit is_edge(int line);
    return (line % 2) == 1;
  endfunction

  function automatic int ext_target(int n);
    int tbl[8] = '{1, 3, 6, 11, 16, 21, 26, 31};
    return tbl[n];
  endfunction

  function automatic int model_level();
    for (int l = 7; l > int'(cur_level); l--)
      for (int i = 0; i < 32; i++)
        if (m_set[i] && m_en[i] && level_of(i) == l) return l;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_set[i] <= 0; m_en[i] <= 0; end
    end else begin
      int tgt;
      bit nxt [32];
      for (int i = 0; i < 32; i++) begin
        nxt[i] = m_set[i];
        if (clr_we && clr_mask[i] && is_edge(i)) nxt[i] = 0;
      end
      tgt = -1;
      if (evt_valid) begin
        if (evt_is_ext) tgt = (evt_num < 8) ? ext_target(int'(evt_num)) : -1;
        else            tgt = (evt_num < 32) ? int'(evt_num) : -1;
      end
      if (tgt >= 0) begin
        if (evt_active) nxt[tgt] = 1;
        else if (!is_edge(tgt)) nxt[tgt] = 0;
      end
      for (int i = 0; i < 32; i++) begin
        m_set[i] <= nxt[i];
        if (en_we) m_en[i] <= en_wdata[i];
      end
    end
  end

  task automatic check(string tag, int exp_lvl);
    total++;
    if (int'(pend_level) != exp_lvl || irq_req != (exp_lvl != 0)) begin
      bad++;
      $display("FAIL %s: pend_level=%0d irq_req=%0d expected pend_level=%0d irq_req=%0d",
               tag, pend_level, irq_req, exp_lvl, exp_lvl != 0);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) check({phase, " model"}, model_level());
  end

  // Stimulus helpers --------------------------------------------------------
  task automatic cycle(bit v, bit ext, int num, bit act,
                       bit cw, logic [31:0] cm, bit ew, logic [31:0] ed);
    @(negedge clk);
    evt_valid = v; evt_is_ext = ext; evt_num = 6'(num); evt_active = act;
    clr_we = cw; clr_mask = cm; en_we = ew; en_wdata = ed;
    @(negedge clk);
    evt_valid = 0; clr_we = 0; en_we = 0;
  endtask

  task automatic line(int num, bit act);
    cycle(1, 0, num, act, 0, '0, 0, '0);
  endtask

  task automatic ext(int num, bit act);
    cycle(1, 1, num, act, 0, '0, 0, '0);
  endtask

  task automatic clear(logic [31:0] m);
    cycle(0, 0, 0, 0, 1, m, 0, '0);
  endtask

  task automatic enable(logic [31:0] m);
    cycle(0, 0, 0, 0, 0, '0, 1, m);
  endtask

  task automatic set_cur(int l);
    @(negedge clk);
    cur_level = 3'(l);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 0);

    phase = "R5";
    line(2, 1);
    check("R5 disabled line hidden", 0);
    enable(32'hFFFF_FFFF);
    check("R10 R5 enable shows latched line", 1);

    phase = "R2";
    line(2, 0);
    check("R2 level-sensitive release", 0);
    line(9, 1);
    check("R1 edge line set", 2);
    line(9, 0);
    check("R2 edge-sensitive hold", 2);
    clear(32'h0000_0200);
    check("R8 clear edge bit", 0);

    phase = "R3";
    line(40, 1);
    check("R3 index 40 ignored", 0);
    line(32, 1);
    check("R3 index 32 ignored", 0);

    phase = "R4";
    ext(3, 1);
    check("R4 ext 3 to line 11", 2);
    clear(32'h0000_0800);
    check("R4 line 11 cleared", 0);
    ext(9, 1);
    check("R4 ext 9 rejected", 0);
    ext(7, 1);
    check("R4 ext 7 to line 31", 7);
    clear(32'h8000_0000);

    phase = "R6";
    line(4, 1); line(17, 1); line(28, 1);
    check("R6 highest of three", 7);
    set_cur(6);
    check("R6 level 7 above 6", 7);
    set_cur(7);
    check("R7 current at top blocks", 0);
    set_cur(0);
    line(28, 0);
    check("R6 next level down", 4);
    set_cur(4);
    check("R7 equal level blocks", 0);
    set_cur(3);
    check("R10 R6 level 4 above 3", 4);
    set_cur(0);

    phase = "R5";
    enable(32'h0000_0010);
    check("R5 only line 4 enabled", 1);
    enable(32'h0);
    check("R5 nothing enabled", 0);
    enable(32'hFFFF_FFFF);
    check("R5 re-enabled", 4);

    phase = "R8";
    clear(32'h0002_0010);
    check("R8 edge cleared level kept", 1);
    cycle(1, 0, 17, 1, 1, 32'h0002_0000, 0, '0);
    check("R8 set wins over clear", 4);
    cycle(1, 0, 4, 0, 1, 32'h0002_0000, 0, '0);
    check("R8 R2 both gone", 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule